// File: doc/BRIEF.md
# Fly-By Block Transfer Engine with Bus Hold Handshake

This block moves blocks of words between an I/O device and memory without ever holding the data. It owns four channels. The processor loads each channel with a direction, a start address and a word count. Once a channel is loaded, a request from its device makes the engine ask the processor for the bus. When the processor grants the bus, the engine acknowledges the device. Then, on every cycle, it drives one memory address together with a memory strobe and the opposite I/O strobe. The device and the memory exchange the word directly on the shared data lines.

Each transfer step moves the address up by one and the remaining count down by one. When the count is used up, the engine releases the bus and marks the channel complete. It also raises an interrupt, which stays up until the processor reads the completion flags. A channel serves one block per load and then goes idle. Only one channel works at a time, and a lower channel number wins when several are waiting.

The controller is a five-state machine:
- **IDLE** goes to **HOLD** when a loaded channel is requesting and the bus grant is low. The winning channel is latched on this transition.
- **HOLD** drives the bus request and stays there until the grant arrives, then goes to **ACK**.
- **ACK** acknowledges the device for one cycle with no strobes, then goes to **XFER**.
- **XFER** moves one word per cycle. It goes to **DONE** after the last word.
- **DONE** drops the request and the acknowledge, then returns to **IDLE**.

Top module: `flyby_dma`

## Requirements
- R1: After reset, `hrq`, `dack`, all four strobes, `irq` and `stat_q` are zero.
- R2: A write with `cfg_we` loads the channel named by `cfg_chan`. A nonzero `cfg_count` arms the channel. A zero count leaves it unarmed. A request on an unarmed channel never raises `hrq`.
- R3: A request on an armed channel, with `hlda` low, raises `hrq` on the next cycle. While `hlda` is low, `dack` and the strobes stay low. One cycle after `hlda` is seen high, `dack` rises with no strobe. Strobes start on the cycle after that.
- R4: At most one `dack` bit is high at a time. When several armed channels request, the lowest-numbered channel is served first, and the others follow in ascending order.
- R5: Strobes appear only while `hlda` and a `dack` bit are high. The pair depends on `cfg_dir`. Direction 0 (memory to device) drives `mem_rd` with `io_wr`. Direction 1 (device to memory) drives `io_rd` with `mem_wr`. One word moves per cycle.
- R6: Exactly `count` consecutive strobe cycles occur. The first word uses the start address, and each later word uses the previous address plus one, modulo 2^ADDR_W.
- R7: On the cycle after the last word, `hrq`, `dack` and all strobes are low. The channel is then unarmed, so a new request on it is ignored until it is loaded again.
- R8: Completion sets that channel's flag and `irq` is high while any flag is set. A `stat_rd` pulse copies the flags to `stat_q` on the next cycle and clears them, which drops `irq`.
- R9: A load aimed at the channel in service, from its selection until its return to IDLE, is ignored. The block in progress keeps its address sequence and word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Channel load strobe |
| cfg_chan | input | 2 | Channel to load |
| cfg_dir | input | 1 | 0 = memory to device, 1 = device to memory |
| cfg_addr | input | 16 | Start memory address |
| cfg_count | input | 16 | Number of words |
| stat_rd | input | 1 | Read-and-clear of completion flags |
| stat_q | output | 4 | Completion flags captured by the last read |
| irq | output | 1 | High while any completion flag is set |
| dreq | input | 4 | Device service requests, one per channel |
| dack | output | 4 | Device acknowledges, one per channel |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Bus hold grant from the processor |
| mem_addr | output | 16 | Memory address of the current word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |

## Verification
The hardest case to reach from the ports is a load that lands on the channel while that same channel is mid-block (R9). The bench gets there by issuing the load from inside its word-by-word observation loop, on the second word of a four-word block. It then checks that the remaining words keep the original addresses and count. Release and reselection under back-to-back pending requests (R4) is just as hard to reach. The bench covers it by raising three requests at once and then following each block in turn. In that run the bench drops the grant in the release cycle so the next request can start.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ACK,
        ST_XFER,
        ST_DONE
    } dma_state_t;

    typedef enum logic {
        DIR_MEM2IO = 1'b0,
        DIR_IO2MEM = 1'b1
    } dma_dir_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dma_dir_t          wr_dir,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic              lock,
    input  logic              step,
    output logic              armed,
    output dma_dir_t          dir,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            dir   <= DIR_MEM2IO;
            addr  <= '0;
            cnt   <= '0;
        end else if (step) begin
            addr <= addr + ADDR_W'(1);
            cnt  <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                armed <= 1'b0;
            end
        end else if (wr_en && !lock) begin
            dir   <= wr_dir;
            addr  <= wr_addr;
            cnt   <= wr_cnt;
            armed <= (wr_cnt != '0);
        end
    end

    assign last = (cnt == CNT_W'(1));

    // R6: a word is only moved for a channel that still has words left
    a_r6_step_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> armed);

    // R7: the final word leaves the channel unarmed
    a_r7_disarm_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> !armed);

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N_CH = 4,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] req,
    output logic [CH_W-1:0] gnt,
    output logic            any
);

    always_comb begin
        gnt = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt = CH_W'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int CH_W  = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_dir,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              stat_rd,
    output logic [N_CH-1:0]   stat_q,
    output logic              irq,
    input  logic [N_CH-1:0]   dreq,
    output logic [N_CH-1:0]   dack,
    output logic              hrq,
    input  logic              hlda,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr
);

    dma_state_t        state, nxt;
    logic [CH_W-1:0]   act_ch;
    logic [CH_W-1:0]   pick_ch;
    logic              pick_any;
    logic [N_CH-1:0]   armed_v;
    logic [N_CH-1:0]   last_v;
    logic [N_CH-1:0]   tc_flags;
    logic [ADDR_W-1:0] addr_v [N_CH];
    dma_dir_t          dir_v  [N_CH];

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_chan
            logic sel_wr, is_act;
            assign sel_wr = cfg_we && (cfg_chan == CH_W'(g));
            assign is_act = (act_ch == CH_W'(g));
            dma_chan_regs #(
                .ADDR_W (ADDR_W),
                .CNT_W  (CNT_W)
            ) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (sel_wr),
                .wr_dir  (dma_dir_t'(cfg_dir)),
                .wr_addr (cfg_addr),
                .wr_cnt  (cfg_count),
                .lock    (is_act && (state != ST_IDLE)),
                .step    (is_act && (state == ST_XFER)),
                .armed   (armed_v[g]),
                .dir     (dir_v[g]),
                .addr    (addr_v[g]),
                .last    (last_v[g])
            );
        end
    endgenerate

    dma_prio_pick #(.N_CH(N_CH)) u_pick (
        .req (dreq & armed_v),
        .gnt (pick_ch),
        .any (pick_any)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (pick_any && !hlda) nxt = ST_HOLD;
            ST_HOLD: if (hlda) nxt = ST_ACK;
            ST_ACK:  nxt = ST_XFER;
            ST_XFER: if (last_v[act_ch]) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register, channel latch, completion flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            act_ch   <= '0;
            tc_flags <= '0;
            stat_q   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_HOLD) begin
                act_ch <= pick_ch;
            end
            if (stat_rd) begin
                stat_q <= tc_flags;
            end
            for (int i = 0; i < N_CH; i++) begin
                if (state == ST_XFER && last_v[i] && act_ch == CH_W'(i)) begin
                    tc_flags[i] <= 1'b1;
                end else if (stat_rd) begin
                    tc_flags[i] <= 1'b0;
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        hrq      = 1'b0;
        dack     = '0;
        mem_addr = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        unique case (state)
            ST_HOLD: hrq = 1'b1;
            ST_ACK: begin
                hrq  = 1'b1;
                dack = N_CH'(1) << act_ch;
            end
            ST_XFER: begin
                hrq      = 1'b1;
                dack     = N_CH'(1) << act_ch;
                mem_addr = addr_v[act_ch];
                if (dir_v[act_ch] == DIR_MEM2IO) begin
                    mem_rd = 1'b1;
                    io_wr  = 1'b1;
                end else begin
                    io_rd  = 1'b1;
                    mem_wr = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign irq = |tc_flags;

    logic any_strobe;
    assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

    // R3: device acknowledge only while the bus is held
    a_r3_dack_under_hrq: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> hrq);

    // R4: never more than one device acknowledged
    a_r4_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R5: strobes only under grant and acknowledge
    a_r5_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> (hlda && (|dack)));

    // R5: strobes come in opposite memory/device pairs
    a_r5_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |-> ((mem_rd && io_wr && !mem_wr && !io_rd) ||
                        (mem_wr && io_rd && !mem_rd && !io_wr)));

    // R6: back-to-back words use consecutive addresses
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && $past(any_strobe)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R8: a new completion flag appears only once the bus is released
    a_r8_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !hrq);

endmodule

// File: tb/flyby_dma_bench.sv
module flyby_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_chan;
    logic        cfg_dir;
    logic [15:0] cfg_addr;
    logic [15:0] cfg_count;
    logic        stat_rd;
    logic [3:0]  stat_q;
    logic        irq;
    logic [3:0]  dreq;
    logic [3:0]  dack;
    logic        hrq;
    logic        hlda;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    flyby_dma u_flyby_dma (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_dir(cfg_dir),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count),
        .stat_rd(stat_rd), .stat_q(stat_q), .irq(irq),
        .dreq(dreq), .dack(dack), .hrq(hrq), .hlda(hlda),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr)
    );

    function automatic logic [3:0] strb();
        return {mem_rd, mem_wr, io_rd, io_wr};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(input int ch, input bit dir,
                        input logic [15:0] addr, input logic [15:0] cnt);
        cfg_we    = 1'b1;
        cfg_chan  = 2'(ch);
        cfg_dir   = dir;
        cfg_addr  = addr;
        cfg_count = cnt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // dreq[ch] must already be high; poke loads the active channel mid-block
    task automatic run_xfer(input int ch, input bit dir, input logic [15:0] start,
                            input int n, input int lat, input bit poke);
        int w = 0;
        logic [3:0] exp_s;
        exp_s = dir ? 4'b0110 : 4'b1001;
        while (!hrq && w < 10) begin
            @(negedge clk);
            w++;
        end
        chk(hrq && w == 1, "R3 hold request one cycle after request", 32'(w), 32'd1);
        for (int i = 0; i < lat; i++) begin
            chk(dack == 4'd0 && strb() == 4'd0 && hrq, "R3 wait for grant",
                32'({dack, strb()}), 32'd0);
            @(negedge clk);
        end
        hlda = 1'b1;
        @(negedge clk);
        chk(dack == 4'(1 << ch), "R4 acknowledge selects channel", 32'(dack), 32'(1 << ch));
        chk(strb() == 4'd0, "R3 no strobe in acknowledge cycle", 32'(strb()), 32'd0);
        dreq[ch] = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(strb() == exp_s, "R5 strobe pair", 32'(strb()), 32'(exp_s));
            chk(mem_addr == 16'(start + 16'(k)), "R6 word address",
                32'(mem_addr), 32'(16'(start + 16'(k))));
            if (poke && k == 1) begin
                cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_dir = ~dir;
                cfg_addr = 16'h0BAD; cfg_count = 16'd1;
            end
            if (poke && k == 2) cfg_we = 1'b0;
        end
        @(negedge clk);
        chk(!hrq && dack == 4'd0 && strb() == 4'd0, "R7 release after last word",
            32'({hrq, dack, strb()}), 32'd0);
        chk(irq, "R8 interrupt on completion", 32'(irq), 32'd1);
        hlda = 1'b0;
        cfg_we = 1'b0;
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(stat_q == 4'(1 << ch), "R8 completion flag read", 32'(stat_q), 32'(1 << ch));
        chk(!irq, "R8 flag cleared by read", 32'(irq), 32'd0);
    endtask

    task automatic expect_quiet(input int ch, input string req);
        dreq[ch] = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!hrq && dack == 4'd0, req, 32'({hrq, dack}), 32'd0);
        end
        dreq[ch] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        wait (cyc >= 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_chan = '0; cfg_dir = 1'b0;
        cfg_addr = '0; cfg_count = '0; stat_rd = 1'b0; dreq = '0; hlda = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!hrq && dack == 0 && strb() == 0 && !irq && stat_q == 0 && mem_addr == 0,
            "R1 reset state", 32'({hrq, dack, strb(), irq, stat_q}), 32'd0);

        // R2: requests on never-loaded channels and on a zero-count load
        expect_quiet(1, "R2 unarmed channel ignored");
        prog(2, 1'b0, 16'h1234, 16'd0);
        expect_quiet(2, "R2 zero count leaves channel unarmed");

        // sweep channels, directions, counts and grant latencies (R3 R5 R6)
        for (int ch = 0; ch < 4; ch++) begin
            for (int d = 0; d < 2; d++) begin
                for (int ni = 0; ni < 4; ni++) begin
                    int n;
                    logic [15:0] st;
                    n  = (ni == 3) ? 5 : ni + 1;
                    st = 16'(ch * 4096 + n * 16 + d);
                    prog(ch, d[0], st, 16'(n));
                    dreq[ch] = 1'b1;
                    run_xfer(ch, d[0], st, n, (ch + d + n) % 3, 1'b0);
                end
            end
        end

        // R7: a finished channel stays unarmed
        expect_quiet(0, "R7 finished channel ignores request");

        // R6: address wraps modulo 2^16
        prog(3, 1'b1, 16'hFFFF, 16'd3);
        dreq[3] = 1'b1;
        run_xfer(3, 1'b1, 16'hFFFF, 3, 1, 1'b0);

        // R4: three requests at once, served lowest first
        prog(1, 1'b0, 16'h0100, 16'd2);
        prog(2, 1'b1, 16'h0200, 16'd1);
        prog(3, 1'b0, 16'h0300, 16'd3);
        dreq = 4'b1110;
        run_xfer(1, 1'b0, 16'h0100, 2, 0, 1'b0);
        run_xfer(2, 1'b1, 16'h0200, 1, 2, 1'b0);
        run_xfer(3, 1'b0, 16'h0300, 3, 1, 1'b0);

        // R9: load aimed at the active channel during its block is ignored
        prog(0, 1'b0, 16'h0500, 16'd4);
        dreq[0] = 1'b1;
        run_xfer(0, 1'b0, 16'h0500, 4, 1, 1'b1);
        expect_quiet(0, "R9 ignored load did not re-arm channel");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule